// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent down counters behind a small byte-wide register port. The port is driven by a host with an active-low chip select, active-low read and write strobes, a two-bit address and a data byte. Each channel has its own count clock input, its own gate input and one output. A host first writes a control word that picks a channel and sets how that channel's count is transferred over the byte bus. The same word sets whether the channel runs once or repeats, and whether it counts in binary or in packed decimal. The host then writes the start count.

The count clock and gate inputs are sampled into the system clock domain through a short synchronizer. A channel decrements on each sampled rising edge of its count clock while its gate is high. In one-shot mode the output goes high when the count reaches zero and stays high until the next load. In periodic mode the count reloads by itself on reaching zero and the output gives a one-cycle pulse. A start count of zero stands for the full range of the chosen number system.

Top module: `prog_interval_timer`

## Requirements
- R1: Address 0, 1 and 2 reach channels 0, 1 and 2. Address 3 is the control word and can only be written. A read of address 3 returns 8'h00 and changes no state.
- R2: An access happens only in a cycle where cs_n is low and exactly one of rd_n and wr_n is low. In any other cycle no register changes and rdata keeps its value.
- R3: Control word layout: bits [7:6] pick the channel, and the value 3 makes the word ignored. Bits [5:4] set the transfer order: 01 low byte only, 10 high byte only, 11 low byte then high byte, and 00 makes the word ignored. Bit 1 set means periodic, clear means one-shot. Bit 0 set means decimal, clear means binary. Bits [3:2] are don't-care. An accepted word drives the channel's output low, stops counting and resets both byte pointers.
- R4: In low-then-high order a count loads once the high byte arrives, and counting starts only then. A new low byte halts counting until its high byte follows. Low-only order loads a high byte of zero, and high-only order loads a low byte of zero.
- R5: A running channel decrements by one on each rising edge of its count clock input that is seen while its gate input is high. With the gate low the count holds.
- R6: In one-shot mode the output is low from the load until the count reaches zero. It then goes high, counting stops with the count at zero, and the output stays high until the next load or accepted control word.
- R7: In periodic mode, on reaching zero the count reloads the last loaded value and the output is high for exactly one system clock cycle. Otherwise the output is low.
- R8: In decimal mode every 4-bit digit stays in 0..9, and a decrement borrows across digits (0x1000 becomes 0x0999).
- R9: A loaded count of zero means 65536 edges in binary and 10000 edges in decimal: the first decrement from zero gives 0xFFFF or 0x9999.
- R10: A channel read places a byte of the current count on rdata in the cycle after the access. The byte is the low byte in low-only order and the high byte in high-only order. In low-then-high order reads alternate low, high, starting with low after each accepted control word.
- R11: After reset all outputs are low, rdata is 8'h00, no channel counts, and every channel is in one-shot binary mode with low-then-high order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| cnt_clk | input | 3 | Per-channel count clock |
| cnt_gate | input | 3 | Per-channel count enable |
| cnt_out | output | 3 | Per-channel output |

## Verification
The bench builds the timer with its defaults: an 8-bit bus (so 16-bit counts), all three channels, a two-stage input synchronizer, and the decimal counting path present. With decimal counting built in, a full 10000-edge cycle of a zero load fits within the run and shows the terminal edge directly. The binary full range is seen through its first wrap from zero to 0xFFFF. Three channels let every address decode, including the unused control readback, be tried against live counts on neighbouring channels.

// File: rtl/timer_pkg.sv
package timer_pkg;

   // byte transfer order for a channel's count
   typedef enum logic [1:0] {
      ACC_NONE = 2'b00,
      ACC_LO   = 2'b01,
      ACC_HI   = 2'b10,
      ACC_LOHI = 2'b11
   } acc_t;

   typedef struct packed {
      acc_t acc;
      logic periodic;
      logic bcd;
   } cfg_t;

   localparam int ADDR_W   = 2;
   localparam int NUM_ADDR = 1 << ADDR_W;
   localparam int CTRL_ADR = NUM_ADDR - 1;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);

   logic [W-1:0] sh [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) sh[s] <= '0;
      end else begin
         sh[0] <= din;
         for (int s = 1; s < STAGES; s++) sh[s] <= sh[s-1];
      end
   end

   assign q = sh[STAGES-1];

endmodule

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
   import timer_pkg::*;
#(
   parameter int NUM_CNT = 3
) (
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        sel,
   input  logic [1:0]        acc,
   output logic [NUM_CNT-1:0] wr_en,
   output logic [NUM_CNT-1:0] rd_en,
   output logic [NUM_CNT-1:0] cw_we,
   output logic              rd_acc
);

   logic wr_acc;
   logic ctrl_wr;

   // both strobes low at once is not an access
   assign wr_acc  = !cs_n && !wr_n && rd_n;
   assign rd_acc  = !cs_n && !rd_n && wr_n;
   assign ctrl_wr = wr_acc && (addr == ADDR_W'(CTRL_ADR)) && (acc != ACC_NONE);

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_ch
      assign wr_en[i] = wr_acc && (addr == ADDR_W'(i));
      assign rd_en[i] = rd_acc && (addr == ADDR_W'(i));
      assign cw_we[i] = ctrl_wr && (sel == 2'(i));
   end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
   import timer_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter bit BCD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cw_we,
   input  cfg_t              cw_cfg,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              clk_lvl,
   input  logic              gate_lvl,
   output logic [DATA_W-1:0] rd_byte,
   output logic              out
);

   localparam int CNT_W  = 2 * DATA_W;
   localparam int DIGITS = CNT_W / 4;

   cfg_t              cfg_q;
   logic [CNT_W-1:0]  count_q;
   logic [CNT_W-1:0]  reload_q;
   logic [CNT_W-1:0]  dec_val;
   logic [CNT_W-1:0]  load_val;
   logic [DATA_W-1:0] lo_buf;
   logic              wr_hi;
   logic              rd_hi;
   logic              running;
   logic              prev_clk;
   logic              wr_load;
   logic              step;
   logic              tc;

   function automatic logic [CNT_W-1:0] bcd_dec(input logic [CNT_W-1:0] v);
      logic [CNT_W-1:0] r;
      logic             brw;
      r   = v;
      brw = 1'b1;
      for (int d = 0; d < DIGITS; d++) begin
         if (brw) begin
            if (v[d*4 +: 4] == 4'd0) begin
               r[d*4 +: 4] = 4'd9;
            end else begin
               r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
               brw         = 1'b0;
            end
         end
      end
      return r;
   endfunction

   // decrement path: decimal support is optional
   if (BCD_EN) begin : g_bcd
      assign dec_val = cfg_q.bcd ? bcd_dec(count_q) : (count_q - CNT_W'(1));
   end else begin : g_bin
      assign dec_val = count_q - CNT_W'(1);
   end

   always_comb begin
      wr_load  = 1'b0;
      load_val = '0;
      case (cfg_q.acc)
         ACC_LO: begin
            wr_load  = wr_en;
            load_val = {{DATA_W{1'b0}}, wdata};
         end
         ACC_HI: begin
            wr_load  = wr_en;
            load_val = {wdata, {DATA_W{1'b0}}};
         end
         ACC_LOHI: begin
            wr_load  = wr_en && wr_hi;
            load_val = {wdata, lo_buf};
         end
         default: ;
      endcase
   end

   always_comb begin
      case (cfg_q.acc)
         ACC_LO:  rd_byte = count_q[DATA_W-1:0];
         ACC_HI:  rd_byte = count_q[CNT_W-1:DATA_W];
         default: rd_byte = rd_hi ? count_q[CNT_W-1:DATA_W] : count_q[DATA_W-1:0];
      endcase
   end

   assign step = clk_lvl && !prev_clk && gate_lvl && running;
   assign tc   = step && (count_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q    <= '{acc: ACC_LOHI, periodic: 1'b0, bcd: 1'b0};
         count_q  <= '0;
         reload_q <= '0;
         lo_buf   <= '0;
         wr_hi    <= 1'b0;
         rd_hi    <= 1'b0;
         running  <= 1'b0;
         prev_clk <= 1'b0;
         out      <= 1'b0;
      end else begin
         prev_clk <= clk_lvl;
         if (cw_we) begin
            cfg_q   <= cw_cfg;
            wr_hi   <= 1'b0;
            rd_hi   <= 1'b0;
            running <= 1'b0;
            out     <= 1'b0;
         end else begin
            if (cfg_q.periodic) out <= 1'b0;
            if (rd_en && cfg_q.acc == ACC_LOHI) rd_hi <= !rd_hi;
            if (wr_en && cfg_q.acc == ACC_LOHI) begin
               wr_hi <= !wr_hi;
               if (!wr_hi) begin
                  lo_buf  <= wdata;
                  running <= 1'b0;
               end
            end
            if (wr_load) begin
               count_q  <= load_val;
               reload_q <= load_val;
               running  <= 1'b1;
               out      <= 1'b0;
            end else if (tc) begin
               out <= 1'b1;
               if (cfg_q.periodic) begin
                  count_q <= reload_q;
               end else begin
                  count_q <= '0;
                  running <= 1'b0;
               end
            end else if (step) begin
               count_q <= dec_val;
            end
         end
      end
   end

endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer
   import timer_pkg::*;
#(
   parameter int NUM_CNT     = 3,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit BCD_EN      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n,
   input  logic               rd_n,
   input  logic               wr_n,
   input  logic [1:0]         addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   input  logic [NUM_CNT-1:0] cnt_clk,
   input  logic [NUM_CNT-1:0] cnt_gate,
   output logic [NUM_CNT-1:0] cnt_out
);

   // elaboration-time parameter checks
   if (NUM_CNT < 1 || NUM_CNT > CTRL_ADR) begin : g_bad_num
      $error("NUM_CNT must lie in 1..3");
   end
   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("DATA_W must be even and at least 4");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic [NUM_CNT-1:0] wr_en;
   logic [NUM_CNT-1:0] rd_en;
   logic [NUM_CNT-1:0] cw_we;
   logic               rd_acc;
   cfg_t               cw_cfg;
   logic [DATA_W-1:0]  rd_bytes [NUM_ADDR];

   assign cw_cfg = '{acc:      acc_t'(wdata[DATA_W-3 -: 2]),
                     periodic: wdata[1],
                     bcd:      wdata[0]};

   tmr_bus_decode #(.NUM_CNT(NUM_CNT)) u_dec (
      .cs_n   (cs_n),
      .rd_n   (rd_n),
      .wr_n   (wr_n),
      .addr   (addr),
      .sel    (wdata[DATA_W-1 -: 2]),
      .acc    (wdata[DATA_W-3 -: 2]),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .cw_we  (cw_we),
      .rd_acc (rd_acc)
   );

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_chan
      logic [1:0] sq;

      tmr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .din   ({cnt_gate[i], cnt_clk[i]}),
         .q     (sq)
      );

      tmr_counter #(.DATA_W(DATA_W), .BCD_EN(BCD_EN)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .cw_we    (cw_we[i]),
         .cw_cfg   (cw_cfg),
         .wr_en    (wr_en[i]),
         .rd_en    (rd_en[i]),
         .wdata    (wdata),
         .clk_lvl  (sq[0]),
         .gate_lvl (sq[1]),
         .rd_byte  (rd_bytes[i]),
         .out      (cnt_out[i])
      );
   end

   // unused addresses, including the control word, read as zero
   for (genvar j = NUM_CNT; j < NUM_ADDR; j++) begin : g_pad
      assign rd_bytes[j] = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_acc) begin
         rdata <= rd_bytes[addr];
      end
   end

endmodule

// File: rtl/prog_interval_timer_chk.sv
module prog_interval_timer_chk #(
   parameter int NUM_CNT = 3,
   parameter int DATA_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cs_n,
   input logic               rd_n,
   input logic               wr_n,
   input logic [1:0]         addr,
   input logic [DATA_W-1:0]  wdata,
   input logic [DATA_W-1:0]  rdata,
   input logic [NUM_CNT-1:0] cnt_out
);

   // R10
   read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || rd_n || !wr_n) |=> $stable(rdata));

   // R2
   deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> $stable(rdata));

   // R1
   ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rd_n && wr_n && addr == 2'd3) |=> (rdata == '0));

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cw
      // R3
      cw_clears_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!cs_n && !wr_n && rd_n && addr == 2'd3 &&
          wdata[DATA_W-1 -: 2] == 2'(i) && wdata[DATA_W-3 -: 2] != 2'b00)
         |=> !cnt_out[i]);
   end

endmodule

bind prog_interval_timer prog_interval_timer_chk #(
   .NUM_CNT (NUM_CNT),
   .DATA_W  (DATA_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_n    (cs_n),
   .rd_n    (rd_n),
   .wr_n    (wr_n),
   .addr    (addr),
   .wdata   (wdata),
   .rdata   (rdata),
   .cnt_out (cnt_out)
);

// File: tb/prog_interval_timer_tb.sv
`timescale 1ns/1ps
module prog_interval_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cs_n, rd_n, wr_n;
   logic [1:0] addr;
   logic [7:0] wdata;
   logic [7:0] rdata;
   logic [2:0] cnt_clk, cnt_gate;
   logic [2:0] cnt_out;

   int nchk  = 0;
   int nfail = 0;
   int hi_cyc = 0;

   always #2 clk = ~clk;

   prog_interval_timer u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .cnt_clk(cnt_clk), .cnt_gate(cnt_gate), .cnt_out(cnt_out)
   );

   always @(negedge clk) if (cnt_out[2]) hi_cyc++;

   typedef struct packed {
      logic [1:0]  ch;
      logic [7:0]  cw;
      logic [15:0] ld;
      logic [15:0] np;
      logic [15:0] exp_cnt;
      logic        exp_out;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 8'h30, 16'd10,    16'd3,   16'd7,    1'b0},  // R5 binary one-shot
      '{2'd1, 8'h70, 16'd5,     16'd5,   16'd0,    1'b1},  // R6 reaches zero
      '{2'd2, 8'hB2, 16'd4,     16'd6,   16'd2,    1'b0},  // R7 reload
      '{2'd0, 8'h31, 16'h1000,  16'd1,   16'h0999, 1'b0},  // R8 borrow
      '{2'd1, 8'h73, 16'h0003,  16'd7,   16'h0002, 1'b0},  // R7 R8 periodic decimal
      '{2'd2, 8'hB0, 16'h0100,  16'd257, 16'd0,    1'b1},  // R6 stops at zero
      '{2'd0, 8'h30, 16'h0000,  16'd2,   16'hFFFE, 1'b0},  // R9 binary zero load
      '{2'd1, 8'h71, 16'h0000,  16'd1,   16'h9999, 1'b0},  // R9 decimal zero load
      '{2'd2, 8'hB1, 16'h0020,  16'd11,  16'h0009, 1'b0}   // R8 digit wrap
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      nchk++;
      if (act !== expv) begin
         nfail++;
         $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, expv);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
   endtask

   task automatic raw(input logic c, input logic r, input logic w,
                      input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cs_n = c; rd_n = r; wr_n = w; addr = a; wdata = d;
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      raw(1'b0, 1'b1, 1'b0, a, d);
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      raw(1'b0, 1'b0, 1'b1, a, 8'h00);
      d = rdata;
   endtask

   task automatic rd_count(input logic [1:0] a, output logic [15:0] v);
      logic [7:0] lo, hi;
      bus_rd(a, lo);
      bus_rd(a, hi);
      v = {hi, lo};
   endtask

   task automatic load(input logic [1:0] a, input logic [15:0] v);
      bus_wr(a, v[7:0]);
      bus_wr(a, v[15:8]);
   endtask

   task automatic pulse(input int ch, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); cnt_clk[ch] = 1'b1;
         repeat (2) @(negedge clk);
         cnt_clk[ch] = 1'b0;
         @(negedge clk);
      end
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] cv;
      logic [7:0]  b, b2;
      rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      addr = 2'd0; wdata = 8'h00; cnt_clk = 3'b000; cnt_gate = 3'b000;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      check("R11 outputs after reset", 32'(cnt_out), 32'h0);
      check("R11 rdata after reset", 32'(rdata), 32'h0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         bus_wr(2'd3, VECS[v].cw);
         load(VECS[v].ch, VECS[v].ld);
         cnt_gate[VECS[v].ch] = 1'b1;
         pulse(int'(VECS[v].ch), int'(VECS[v].np));
         rd_count(VECS[v].ch, cv);
         check($sformatf("R5 R8 R9 vector %0d count", v), 32'(cv), 32'(VECS[v].exp_cnt));
         check($sformatf("R6 R7 vector %0d output", v), 32'(cnt_out[VECS[v].ch]),
               32'(VECS[v].exp_out));
      end

      // R7 pulse width: load 2, four edges give two one-cycle pulses
      bus_wr(2'd3, 8'hB2);
      load(2'd2, 16'd2);
      cnt_gate[2] = 1'b1;
      hi_cyc = 0;
      pulse(2, 4);
      check("R7 periodic high cycles", 32'(hi_cyc), 32'd2);
      check("R7 periodic output idle", 32'(cnt_out[2]), 32'd0);
      rd_count(2'd2, cv);
      check("R7 periodic reload value", 32'(cv), 32'd2);

      // R4 a lone low byte halts counting until its high byte
      bus_wr(2'd3, 8'h30);
      load(2'd0, 16'h0010);
      bus_wr(2'd0, 8'h55);
      cnt_gate[0] = 1'b1;
      pulse(0, 3);
      rd_count(2'd0, cv);
      check("R4 halted after low byte", 32'(cv), 32'h0010);
      bus_wr(2'd0, 8'h00);
      pulse(0, 1);
      rd_count(2'd0, cv);
      check("R4 resumed after high byte", 32'(cv), 32'h0054);

      // R5 gate low holds the count
      bus_wr(2'd3, 8'h70);
      load(2'd1, 16'd20);
      cnt_gate[1] = 1'b0;
      pulse(1, 5);
      rd_count(2'd1, cv);
      check("R5 gate low holds", 32'(cv), 32'd20);
      cnt_gate[1] = 1'b1;
      pulse(1, 1);
      cnt_gate[1] = 1'b0;
      rd_count(2'd1, cv);
      check("R5 gate high counts", 32'(cv), 32'd19);

      // R4 R10 single-byte orders
      bus_wr(2'd3, 8'h10);
      bus_wr(2'd0, 8'h22);
      pulse(0, 2);
      bus_rd(2'd0, b);
      bus_rd(2'd0, b2);
      check("R10 low-only first read", 32'(b), 32'h20);
      check("R10 low-only second read", 32'(b2), 32'h20);
      bus_wr(2'd3, 8'h20);
      bus_wr(2'd0, 8'h03);
      bus_rd(2'd0, b);
      bus_rd(2'd0, b2);
      check("R4 high-only load read", 32'(b), 32'h03);
      check("R10 high-only repeat read", 32'(b2), 32'h03);

      // R2 accesses that must be ignored (channel 1 holds 19)
      bus_rd(2'd1, b);
      bus_rd(2'd1, b);
      raw(1'b1, 1'b1, 1'b0, 2'd1, 8'h77);
      raw(1'b1, 1'b1, 1'b0, 2'd1, 8'h77);
      raw(1'b0, 1'b0, 1'b0, 2'd1, 8'h77);
      raw(1'b0, 1'b0, 1'b0, 2'd1, 8'h77);
      raw(1'b1, 1'b0, 1'b1, 2'd1, 8'h00);
      check("R2 rdata held on deselected read", 32'(rdata), 32'h00);
      rd_count(2'd1, cv);
      check("R2 count untouched by ignored writes", 32'(cv), 32'd19);

      // R1 control address reads as zero
      bus_rd(2'd1, b);
      bus_rd(2'd3, b2);
      check("R1 control readback", 32'(b2), 32'h00);
      bus_rd(2'd1, b);
      check("R1 channel pointer unchanged by control read", 32'(b), 32'h00);

      // R3 select 3 is ignored
      bus_wr(2'd3, 8'hF2);
      rd_count(2'd1, cv);
      check("R3 select 3 ignored", 32'(cv), 32'd19);

      // R6 stays high after terminal count; R3 access 00 ignored
      bus_wr(2'd3, 8'h30);
      load(2'd0, 16'd1);
      cnt_gate[0] = 1'b1;
      pulse(0, 1);
      check("R6 high at terminal count", 32'(cnt_out[0]), 32'd1);
      pulse(0, 2);
      check("R6 stays high", 32'(cnt_out[0]), 32'd1);
      rd_count(2'd0, cv);
      check("R6 count held at zero", 32'(cv), 32'd0);
      bus_wr(2'd3, 8'h02);
      check("R3 access 00 ignored", 32'(cnt_out[0]), 32'd1);
      bus_wr(2'd3, 8'h30);
      check("R3 accepted word clears output", 32'(cnt_out[0]), 32'd0);

      // R9 decimal full count of a zero load
      bus_wr(2'd3, 8'h71);
      load(2'd1, 16'h0000);
      cnt_gate[1] = 1'b1;
      pulse(1, 9999);
      check("R9 decimal before last edge", 32'(cnt_out[1]), 32'd0);
      rd_count(2'd1, cv);
      check("R9 decimal count one left", 32'(cv), 32'h0001);
      pulse(1, 1);
      check("R9 decimal terminal after 10000", 32'(cnt_out[1]), 32'd1);

      summary();
      $finish;
   end

endmodule